// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Edge Capture

This block is a single-channel timer built around an up-counter that advances on a tick from a power-of-two clock divider. The counter runs either repeatedly, returning to zero each time it reaches a programmed compare value, or once, in which case it stops itself after the first match. An external input is synchronized and watched for edges. Each rising edge copies the live count into one capture register, and each falling edge copies it into a second one. Software can use this to time pulses or measure periods.

Software reaches the block through a flat register port with one write strobe and a combinational read. Every event sets a raw status bit, whether or not it is masked. Writing ones to the status register clears those bits. The interrupt line is the OR of the status bits that are enabled in the mask register. Turning the timer on clears the count and both captures in the same cycle. Turning it off freezes them.

Top module: `gp_capture_timer`

## Requirements
- R1: After reset the control register reads 0 (timer off, repeating mode, divider code 0). The mask and status registers read 0, the count reads 0, the compare register reads all ones, and irq is low.
- R2: The register addresses are: 0 control, 1 compare, 2 count (read only), 3 rising capture (read only), 4 falling capture (read only), 5 mask, 6 status. In the control word, bit 5 is the run enable, bit 4 is the mode (0 repeating, 1 one-shot) and bits 3:0 are the divider code. Written values read back unchanged.
- R3: With a divider code n from 0 to 8, the counter advances once every 2^n clock cycles. After the enabling write, the value read j cycles later is floor(j/2^n) taken modulo (compare+1).
- R4: Divider codes 9 to 15 produce no ticks, so the count does not move while the timer is enabled.
- R5: A write to the control register that changes the enable bit from 0 to 1 clears the count and both capture registers in that same cycle. Counting starts on the next cycle.
- R6: While the enable bit is 0, the count and both capture registers keep their values, and input edges are not captured.
- R7: In repeating mode, when the counter is at the compare value on a tick, it returns to 0 and sets status bit 0 (match).
- R8: In one-shot mode, the first match returns the count to 0, sets status bit 0 and clears the enable bit, so the control register reads back with bit 5 low.
- R9: The capture input passes through a two-stage synchronizer. While the timer is enabled, a rising edge loads into the rising capture register the count present two cycles after the input changed, and sets status bit 1. A falling edge does the same for the falling capture register and status bit 2.
- R10: Status bits record events whether or not they are masked. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: irq is high exactly when some status bit is set and its mask bit at the same position is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | CNT_W (16) | Write data |
| reg_rdata | output | CNT_W (16) | Read data for reg_addr, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Masked interrupt |

## Verification
Repeating-mode runs are drawn at random over divider codes 0 to 8, compare values 0 to 40 and run lengths up to 300 cycles. Each run is checked against floor(j/2^n) mod (compare+1) and against the expected match flag. These runs separate an off-by-one in the divider from one in the wrap point. Directed cases cover the remaining behaviour:
- a one-shot run sampled just before and well after its single match, to show that the enable bit clears itself;
- an illegal divider code;
- a disable in the middle of a count, which shows the freeze and the tick taken on the disabling edge;
- edges on the capture input at known counts, which pin down the synchronizer latency;
- edges applied while the timer is off;
- walks through the mask and status registers, which separate raw status from the masked interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned REG_AW = 3;
   localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
   localparam logic [REG_AW-1:0] A_CMP  = 3'd1;
   localparam logic [REG_AW-1:0] A_CNT  = 3'd2;
   localparam logic [REG_AW-1:0] A_RCAP = 3'd3;
   localparam logic [REG_AW-1:0] A_FCAP = 3'd4;
   localparam logic [REG_AW-1:0] A_MASK = 3'd5;
   localparam logic [REG_AW-1:0] A_STAT = 3'd6;
   localparam int unsigned ST_MATCH = 0;
   localparam int unsigned ST_RISE  = 1;
   localparam int unsigned ST_FALL  = 2;
   localparam int unsigned ST_W     = 3;
   localparam int unsigned CTL_EN   = 5;
   localparam int unsigned CTL_MODE = 4;
   typedef struct packed {
      logic       en;
      logic       one_shot;
      logic [3:0] code;
   } ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned MAX_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clr,
   input  logic [3:0] code,
   output logic       tick
);
   localparam int unsigned PW = MAX_LOG2;
   logic [PW-1:0] pc_q;
   logic [PW:0]   full;
   logic          legal;

   always_comb begin
      legal = (code <= 4'(MAX_LOG2));
      full  = ((PW+1)'(1) << code) - (PW+1)'(1);
      tick  = run & legal & ((pc_q & full[PW-1:0]) == full[PW-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc_q <= '0;
      else if (clr) pc_q <= '0;
      else if (run) pc_q <= pc_q + PW'(1);
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             match
);
   logic [CNT_W-1:0] cnt_q;

   assign match = tick && (cnt_q == cmp);
   assign cnt   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic prev
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign level = sh_q[STAGES-1];
   assign prev  = sh_q[STAGES];
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
   parameter int unsigned CNT_W  = 16,
   parameter bit          RISING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             arm,
   input  logic             level,
   input  logic             prev,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             evt
);
   logic edge_seen;

   generate
      if (RISING) begin : g_rise
         assign edge_seen = level & ~prev;
      end else begin : g_fall
         assign edge_seen = ~level & prev;
      end
   endgenerate

   assign evt = arm & edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap <= '0;
      else if (clr) cap <= '0;
      else if (evt) cap <= cnt;
   end
endmodule

// File: rtl/gp_capture_timer.sv
module gp_capture_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned MAX_LOG2    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = REG_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              cap_in,
   output logic              irq
);
   generate
      if (CNT_W < 6)                       begin : g_bad_w  $error("CNT_W too small"); end
      if (MAX_LOG2 < 1 || MAX_LOG2 > 15)   begin : g_bad_p  $error("MAX_LOG2 out of range"); end
      if (SYNC_STAGES < 2)                 begin : g_bad_s  $error("SYNC_STAGES below 2"); end
      if (ADDR_W < REG_AW)                 begin : g_bad_a  $error("ADDR_W too small"); end
   endgenerate

   ctl_t             ctl_q;
   logic [CNT_W-1:0] cmp_q;
   logic [ST_W-1:0]  mask_q, stat_q, stat_set, stat_clr;
   logic             wr_ctrl, wr_stat, start, tick, match;
   logic [CNT_W-1:0] cnt, rise_cap, fall_cap;
   logic [CNT_W-1:0] cap_arr [2];
   logic [1:0]       cap_evt;
   logic             s_level, s_prev;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
   assign start   = wr_ctrl && reg_wdata[CTL_EN] && !ctl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cmp_q  <= '1;
         mask_q <= '0;
      end else begin
         if (wr_ctrl)
            ctl_q <= ctl_t'({reg_wdata[CTL_EN], reg_wdata[CTL_MODE], reg_wdata[3:0]});
         else if (match && ctl_q.one_shot)
            ctl_q.en <= 1'b0;
         if (reg_wr && reg_addr == ADDR_W'(A_CMP))  cmp_q  <= reg_wdata;
         if (reg_wr && reg_addr == ADDR_W'(A_MASK)) mask_q <= reg_wdata[ST_W-1:0];
      end
   end

   tmr_prescaler #(.MAX_LOG2(MAX_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctl_q.en), .clr(start),
      .code(ctl_q.code), .tick(tick));

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(start), .tick(tick),
      .cmp(cmp_q), .cnt(cnt), .match(match));

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .level(s_level), .prev(s_prev));

   for (genvar g = 0; g < 2; g++) begin : g_cap
      tmr_capture #(.CNT_W(CNT_W), .RISING(g == 0)) u_cap (
         .clk(clk), .rst_n(rst_n), .clr(start), .arm(ctl_q.en),
         .level(s_level), .prev(s_prev), .cnt(cnt),
         .cap(cap_arr[g]), .evt(cap_evt[g]));
   end

   assign rise_cap = cap_arr[0];
   assign fall_cap = cap_arr[1];

   always_comb begin
      stat_set           = '0;
      stat_set[ST_MATCH] = match;
      stat_set[ST_RISE]  = cap_evt[0];
      stat_set[ST_FALL]  = cap_evt[1];
      stat_clr           = wr_stat ? reg_wdata[ST_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_clr) | stat_set;
   end

   assign irq = |(stat_q & mask_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL): reg_rdata = {{(CNT_W-6){1'b0}}, ctl_q};
         ADDR_W'(A_CMP):  reg_rdata = cmp_q;
         ADDR_W'(A_CNT):  reg_rdata = cnt;
         ADDR_W'(A_RCAP): reg_rdata = rise_cap;
         ADDR_W'(A_FCAP): reg_rdata = fall_cap;
         ADDR_W'(A_MASK): reg_rdata = {{(CNT_W-ST_W){1'b0}}, mask_q};
         ADDR_W'(A_STAT): reg_rdata = {{(CNT_W-ST_W){1'b0}}, stat_q};
         default:         reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned MAX_LOG2 = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             one_shot,
   input logic [3:0]       code,
   input logic             wr_ctrl,
   input logic             wen_bit,
   input logic             match,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] rcap,
   input logic [CNT_W-1:0] fcap,
   input logic [2:0]       mask,
   input logic             irq
);
   // R6
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_ctrl) |=> ($stable(cnt) && $stable(rcap) && $stable(fcap)));

   // R4
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && code > 4'(MAX_LOG2) && !wr_ctrl) |=> $stable(cnt));

   // R5
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wen_bit && !en) |=> (cnt == '0 && rcap == '0 && fcap == '0));

   // R7
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (cnt == '0));

   // R8
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && one_shot && !wr_ctrl) |=> !en);

   // R11
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 3'b000) |-> !irq);
endmodule

bind gp_capture_timer tmr_chk #(.CNT_W(CNT_W), .MAX_LOG2(MAX_LOG2)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .one_shot(ctl_q.one_shot),
   .code(ctl_q.code), .wr_ctrl(wr_ctrl), .wen_bit(reg_wdata[5]),
   .match(match), .cnt(cnt), .rcap(rise_cap), .fcap(fall_cap),
   .mask(mask_q), .irq(irq));

// File: tb/gp_capture_timer_tb.sv
module gp_capture_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        cap_in = 1'b0;
   logic        irq;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   gp_capture_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .irq(irq));

   function automatic logic [15:0] exp_count(int j, int code, int cmp);
      return 16'(((j >> code) % (cmp + 1)));
   endfunction

   function automatic logic exp_match(int j, int code, int cmp);
      return (j >> code) > cmp;
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); check("R1 ctrl", v, 16'h0000);
      rd(3'd1, v); check("R1 compare", v, 16'hFFFF);
      rd(3'd2, v); check("R1 count", v, 16'h0000);
      rd(3'd5, v); check("R1 mask", v, 16'h0000);
      rd(3'd6, v); check("R1 status", v, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);

      // R2 readback of control fields without enable
      wr(3'd0, 16'h0017); rd(3'd0, v); check("R2 ctrl readback", v, 16'h0017);
      wr(3'd0, 16'h0000);

      // R3 R7 random repeating-mode runs
      for (int k = 0; k < 14; k++) begin
         int code = $urandom_range(0, 8);
         int cmp  = $urandom_range(0, 40);
         int j    = $urandom_range(0, 300);
         if (k == 0) begin code = 0; cmp = 0; j = 5; end
         if (k == 1) begin code = 8; cmp = 1; j = 600; end
         wr(3'd0, 16'h0000);
         wr(3'd1, 16'(cmp));
         wr(3'd6, 16'h0007);
         wr(3'd0, 16'h0020 | 16'(code));
         idle(j);
         rd(3'd2, v); check("R3 count", v, exp_count(j, code, cmp));
         rd(3'd6, v); check("R7 match status", {15'd0, v[0]}, {15'd0, exp_match(j, code, cmp)});
      end

      // R8 one-shot, code 1, compare 3: ticks on cycles 2,4,6,8
      wr(3'd0, 16'h0000);
      wr(3'd1, 16'd3);
      wr(3'd6, 16'h0007);
      wr(3'd0, 16'h0031);
      idle(7);
      rd(3'd2, v); check("R8 count before match", v, 16'd3);
      rd(3'd0, v); check("R8 still enabled", v, 16'h0031);
      idle(13);
      rd(3'd2, v); check("R8 count after match", v, 16'd0);
      rd(3'd0, v); check("R8 enable cleared", v, 16'h0011);
      rd(3'd6, v); check("R8 match status", v, 16'h0001);

      // R4 illegal divider code
      wr(3'd0, 16'h0000);
      wr(3'd1, 16'd1000);
      wr(3'd0, 16'h0029);
      idle(30);
      rd(3'd2, v); check("R4 count held", v, 16'd0);

      // R6 freeze on disable, R5 clear on enable
      wr(3'd0, 16'h0000);
      wr(3'd0, 16'h0020);
      idle(50);
      rd(3'd2, v); check("R3 count 50", v, 16'd50);
      wr(3'd0, 16'h0000);
      idle(20);
      rd(3'd2, v); check("R6 count frozen", v, 16'd51);
      wr(3'd0, 16'h0020);
      rd(3'd2, v); check("R5 count cleared", v, 16'd0);

      // R9 capture latency and polarity
      wr(3'd0, 16'h0000);
      wr(3'd6, 16'h0007);
      wr(3'd0, 16'h0020);
      idle(10);
      cap_in = 1'b1;
      idle(5);
      rd(3'd3, v); check("R9 rising capture", v, 16'd12);
      rd(3'd6, v); check("R9 rise status", v, 16'h0002);
      cap_in = 1'b0;
      idle(5);
      rd(3'd4, v); check("R9 falling capture", v, 16'd17);
      rd(3'd6, v); check("R10 raw status unmasked", v, 16'h0006);
      check("R11 irq masked off", {15'd0, irq}, 16'h0000);

      // R6 no capture while off
      wr(3'd0, 16'h0000);
      cap_in = 1'b1;
      idle(6);
      rd(3'd3, v); check("R6 rising capture held", v, 16'd12);

      // R11 mask and R10 write-one-to-clear
      wr(3'd5, 16'h0002);
      check("R11 irq on rise", {15'd0, irq}, 16'h0001);
      wr(3'd6, 16'h0002);
      rd(3'd6, v); check("R10 rise cleared only", v, 16'h0004);
      check("R11 irq after clear", {15'd0, irq}, 16'h0000);
      wr(3'd5, 16'h0004);
      check("R11 irq on fall", {15'd0, irq}, 16'h0001);
      wr(3'd6, 16'h0000);
      rd(3'd6, v); check("R10 zero write no effect", v, 16'h0004);
      wr(3'd6, 16'h0007);
      check("R11 irq all clear", {15'd0, irq}, 16'h0000);

      // R5 captures cleared by re-enable
      wr(3'd0, 16'h0020);
      rd(3'd3, v); check("R5 rising capture cleared", v, 16'd0);
      rd(3'd4, v); check("R5 falling capture cleared", v, 16'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule